// File: doc/BRIEF.md
# Packed-decimal arithmetic digit shifter

This block moves the digit field of a packed-decimal accumulator a signed number of digit positions in one pass. The accumulator holds 31 BCD digits above a four-bit sign nibble. A positive count moves digits toward the more significant end and a negative count moves them toward the less significant end. The sign nibble stays where it is, and the result keeps that sign even when every digit ends up zero.

The signed count comes from a 16-bit field of a supplied count word. When indexing is requested, a 16-bit field cut from an index word is added to it. An accumulator that holds a non-BCD digit or an invalid sign is passed through unchanged and flagged. The results are registered and appear one clock after the inputs are sampled. The instruction sequencer drives the inputs and takes the results.

Top module: `dec_shift_arith`

## Requirements
- R1: Without indexing (`idx_en`=0), the count is `cnt_word[15:0]` read as a two's-complement number. Bits 31:16 of `cnt_word` and all of `idx_word` are ignored. A count of zero returns the accumulator unchanged.
- R2: With indexing (`idx_en`=1), the count is `cnt_word[15:0] + idx_word[17:2]`, wrapped modulo 2^16 and then read as signed. Bits 31:18 and 1:0 of `idx_word` are ignored.
- R3: A positive count N moves every digit up N nibble positions. Digit nibble k sits at bits 4k+3:4k for k=1..31. Digits shifted past position 31 are lost, and vacated low positions fill with zero.
- R4: A negative count -N moves every digit down N nibble positions. Digits shifted below position 1 are lost, and vacated high positions fill with zero.
- R5: A count magnitude of 31 or more, in either direction, clears all 31 digits. This includes -32768.
- R6: The sign nibble `acc_out[3:0]` always equals the sampled `acc_in[3:0]`. This holds when the resulting digits are all zero.
- R7: A digit nibble above 9, or a sign nibble below 0xA, aborts the operation. `abort` goes to 1, `acc_out` equals `acc_in` unchanged, and `cc_out` is 3.
- R8: When the operation completes, `cc_out` is set as follows:
  - 0 when all result digits are zero.
  - 1 when the digits are non-zero and the sign is 0xB or 0xD.
  - 2 otherwise.
- R9: All results are registered and appear one rising edge after the inputs are sampled. A low `rst_n` at a rising edge clears `acc_out`, `cc_out` and `abort` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_in | input | 128 | Packed-decimal accumulator, sign in bits 3:0 |
| cnt_word | input | 32 | Word holding the immediate count in bits 15:0 |
| idx_word | input | 32 | Index word, count field in bits 17:2 |
| idx_en | input | 1 | Add the index field to the count |
| acc_out | output | 128 | Shifted accumulator |
| cc_out | output | 2 | Result code: 0 zero, 1 negative, 2 positive, 3 aborted |
| abort | output | 1 | Illegal digit or sign detected |

## Verification
Each result is due at the first rising edge after its inputs are presented. The shifted value, the result code and the abort flag all come out of the same register stage, so they share that latency. The bench changes inputs on the falling edge and samples 1 ns after the next rising edge. In one directed case it also samples just after the falling edge, to confirm that the outputs have not yet moved. Reset is checked the same way: `rst_n` is applied at a falling edge and the cleared outputs are sampled after the following rising edge.

// File: rtl/dsh_pkg.sv
// Shared types and helpers for the packed-decimal digit shifter.
// Assumes the sign nibble codes 0xA..0xF, of which 0xB and 0xD are minus.
package dsh_pkg;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2,
        CC_ERR  = 2'd3
    } dsh_cc_e;

    localparam logic [3:0] SIGN_MIN  = 4'hA;
    localparam logic [3:0] DIGIT_MAX = 4'h9;

    // True for the two minus sign codes.
    function automatic logic is_minus(input logic [3:0] s);
        return (s == 4'hB) || (s == 4'hD);
    endfunction

endpackage

// File: rtl/dsh_count.sv
// Forms the signed digit count from the immediate field, plus an optional
// index field, then splits it into a direction and an unsigned magnitude.
// Assumes WW >= IDX_LO + CW. The sum wraps modulo 2^CW.
module dsh_count #(
    parameter int CW     = 16,
    parameter int WW     = 32,
    parameter int IDX_LO = 2
) (
    input  logic [WW-1:0] cnt_word,
    input  logic [WW-1:0] idx_word,
    input  logic          idx_en,
    output logic          go_left,
    output logic [CW-1:0] mag
);

    logic [CW-1:0] idx_part;
    logic [CW-1:0] sum;

    // Add the selected index field to the immediate field.
    always_comb begin
        idx_part = idx_en ? idx_word[IDX_LO+CW-1:IDX_LO] : '0;
        sum      = cnt_word[CW-1:0] + idx_part;
    end

    // Sign gives the direction; the magnitude is the absolute value.
    always_comb begin
        go_left = ~sum[CW-1];
        mag     = sum[CW-1] ? (~sum + CW'(1)) : sum;
    end

endmodule

// File: rtl/dsh_legal.sv
// Flags a nibble outside BCD in the digit field, or a sign code below 0xA.
// Assumes the sign sits in the lowest nibble.
module dsh_legal
    import dsh_pkg::*;
#(
    parameter int NDIG = 31,
    localparam int AW  = 4 * NDIG + 4
) (
    input  logic [AW-1:0] acc,
    output logic          bad
);

    logic [NDIG-1:0] dig_bad;

    // One range test per digit nibble.
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign dig_bad[i] = acc[4*i+7 -: 4] > DIGIT_MAX;
    end

    // Combine digit and sign verdicts.
    assign bad = (|dig_bad) || (acc[3:0] < SIGN_MIN);

endmodule

// File: rtl/dsh_barrel.sv
// Logarithmic digit shifter over NDIG nibbles, with zero fill.
// Assumes the magnitude is unsigned. Any value of NDIG or more clears the field.
module dsh_barrel #(
    parameter int NDIG = 31,
    parameter int CW   = 16,
    localparam int DW  = 4 * NDIG,
    localparam int STG = $clog2(NDIG + 1)
) (
    input  logic [DW-1:0] din,
    input  logic          go_left,
    input  logic [CW-1:0] mag,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] st [STG+1];

    assign st[0] = din;

    // Stage s moves by 2^s digits when magnitude bit s is set.
    for (genvar s = 0; s < STG; s++) begin : g_stage
        localparam int SH = 4 * (2 ** s);
        assign st[s+1] = !mag[s] ? st[s]
                       : go_left ? (st[s] << SH)
                       :           (st[s] >> SH);
    end

    // Magnitudes beyond the field width empty it.
    assign dout = (mag >= CW'(NDIG)) ? '0 : st[STG];

endmodule

// File: rtl/dec_shift_arith.sv
// Top level of the packed-decimal digit shifter. It checks the accumulator,
// forms the count, shifts the digits and keeps the sign, then registers the
// value, the result code and the abort flag. Latency is one clock.
// Assumes a synchronous active-low reset.
module dec_shift_arith
    import dsh_pkg::*;
#(
    parameter int NDIG   = 31,
    parameter int CW     = 16,
    parameter int WW     = 32,
    parameter int IDX_LO = 2,
    localparam int DW    = 4 * NDIG,
    localparam int AW    = DW + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] acc_in,
    input  logic [WW-1:0] cnt_word,
    input  logic [WW-1:0] idx_word,
    input  logic          idx_en,
    output logic [AW-1:0] acc_out,
    output logic [1:0]    cc_out,
    output logic          abort
);

    logic          go_left;
    logic [CW-1:0] mag;
    logic          bad;
    logic [DW-1:0] shifted;
    dsh_cc_e       cc_next;
    logic [AW-1:0] acc_next;

    dsh_count #(.CW(CW), .WW(WW), .IDX_LO(IDX_LO)) u_count (
        .cnt_word (cnt_word),
        .idx_word (idx_word),
        .idx_en   (idx_en),
        .go_left  (go_left),
        .mag      (mag)
    );

    dsh_legal #(.NDIG(NDIG)) u_legal (
        .acc (acc_in),
        .bad (bad)
    );

    dsh_barrel #(.NDIG(NDIG), .CW(CW)) u_barrel (
        .din     (acc_in[AW-1:4]),
        .go_left (go_left),
        .mag     (mag),
        .dout    (shifted)
    );

    // Choose the next accumulator and result code.
    always_comb begin
        if (bad) begin
            acc_next = acc_in;
            cc_next  = CC_ERR;
        end else begin
            acc_next = {shifted, acc_in[3:0]};
            if (shifted == '0)
                cc_next = CC_ZERO;
            else if (is_minus(acc_in[3:0]))
                cc_next = CC_NEG;
            else
                cc_next = CC_POS;
        end
    end

    // Result register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out <= '0;
            cc_out  <= 2'd0;
            abort   <= 1'b0;
        end else begin
            acc_out <= acc_next;
            cc_out  <= cc_next;
            abort   <= bad;
        end
    end

endmodule

// File: rtl/dec_shift_arith_chk.sv
// Protocol checker for dec_shift_arith, attached by bind. It watches only
// the top-level ports and keeps one flag that marks a completed cycle
// after reset.
module dec_shift_arith_chk #(
    parameter int NDIG   = 31,
    parameter int CW     = 16,
    parameter int WW     = 32,
    localparam int AW    = 4 * NDIG + 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] acc_in,
    input logic [WW-1:0] cnt_word,
    input logic          idx_en,
    input logic [AW-1:0] acc_out,
    input logic [1:0]    cc_out,
    input logic          abort
);

    logic primed;

    // Marks that the outputs reflect a sampled input.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R7
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (acc_out == $past(acc_in)) && (cc_out == 2'd3));

    // R6
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> acc_out[3:0] == $past(acc_in[3:0]));

    // R8
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !abort && acc_out[AW-1:4] == '0) |-> cc_out == 2'd0);

    // R8
    neg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_out == 2'd1) |-> (acc_out[3:0] == 4'hB || acc_out[3:0] == 4'hD));

    // R1
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !abort && $past(!idx_en && cnt_word[CW-1:0] == '0))
        |-> acc_out == $past(acc_in));

    // R5
    wide_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !abort && $past(!idx_en && !cnt_word[CW-1]
                                   && cnt_word[CW-1:0] >= CW'(NDIG)))
        |-> acc_out[AW-1:4] == '0);

endmodule

bind dec_shift_arith dec_shift_arith_chk #(
    .NDIG (NDIG),
    .CW   (CW),
    .WW   (WW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_in   (acc_in),
    .cnt_word (cnt_word),
    .idx_en   (idx_en),
    .acc_out  (acc_out),
    .cc_out   (cc_out),
    .abort    (abort)
);

// File: tb/dec_shift_arith_tb.sv
`timescale 1ns/1ps
module dec_shift_arith_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] acc_in = '0;
    logic [31:0]  cnt_word = '0;
    logic [31:0]  idx_word = '0;
    logic         idx_en = 1'b0;
    logic [127:0] acc_out;
    logic [1:0]   cc_out;
    logic         abort;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dec_shift_arith u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_in   (acc_in),
        .cnt_word (cnt_word),
        .idx_word (idx_word),
        .idx_en   (idx_en),
        .acc_out  (acc_out),
        .cc_out   (cc_out),
        .abort    (abort)
    );

    typedef struct packed {
        logic [127:0] acc;
        logic [31:0]  cw;
        logic [31:0]  iw;
        logic         ie;
        logic [127:0] exp;
        logic [1:0]   cc;
        logic         ab;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R3 left 3; R1 index word ignored when idx_en=0
        '{128'h0000_0000_0000_0000_0000_0001_2345_678C, 32'h0000_0003, 32'h0000_0040, 1'b0,
          128'h0000_0000_0000_0000_0000_1234_5678_000C, 2'd2, 1'b0},
        // R4 right 2; R1 upper count bits ignored
        '{128'h0000_0000_0000_0000_0000_0001_2345_678C, 32'hABCD_FFFE, 32'h0000_0000, 1'b0,
          128'h0000_0000_0000_0000_0000_0000_0123_456C, 2'd2, 1'b0},
        // R2 index field 1 plus imm 1, outer index bits ignored
        '{128'h0000_0000_0000_0000_0000_0001_2345_678C, 32'h0000_0001, 32'hFFFC_0007, 1'b1,
          128'h0000_0000_0000_0000_0000_0123_4567_800C, 2'd2, 1'b0},
        // R2 imm 5 plus index -8 gives right 3
        '{128'h0000_0000_0000_0000_0000_0001_2345_678C, 32'h0000_0005, 32'h0003_FFE0, 1'b1,
          128'h0000_0000_0000_0000_0000_0000_0012_345C, 2'd2, 1'b0},
        // R2 wrap 0x7FFF+1 = -32768; R5 clears; R6 sign kept at zero
        '{128'h0000_0000_0000_0000_0000_0001_2345_678C, 32'h0000_7FFF, 32'h0000_0004, 1'b1,
          128'h0000_0000_0000_0000_0000_0000_0000_000C, 2'd0, 1'b0},
        // R3 top digit lost; R8 negative
        '{128'h9000_0000_0000_0000_0000_0000_0000_007D, 32'h0000_0001, 32'h0, 1'b0,
          128'h0000_0000_0000_0000_0000_0000_0000_070D, 2'd1, 1'b0},
        // R4 bottom digit lost
        '{128'h9000_0000_0000_0000_0000_0000_0000_007D, 32'h0000_FFFF, 32'h0, 1'b0,
          128'h0900_0000_0000_0000_0000_0000_0000_000D, 2'd1, 1'b0},
        // R5 left 31 clears; R6 minus sign kept, R8 zero code
        '{128'h9000_0000_0000_0000_0000_0000_0000_007D, 32'h0000_001F, 32'h0, 1'b0,
          128'h0000_0000_0000_0000_0000_0000_0000_000D, 2'd0, 1'b0},
        // R3 left 30 edge
        '{128'h9000_0000_0000_0000_0000_0000_0000_007D, 32'h0000_001E, 32'h0, 1'b0,
          128'h7000_0000_0000_0000_0000_0000_0000_000D, 2'd1, 1'b0},
        // R4 right 30 edge
        '{128'h9000_0000_0000_0000_0000_0000_0000_007D, 32'h0000_FFE2, 32'h0, 1'b0,
          128'h0000_0000_0000_0000_0000_0000_0000_009D, 2'd1, 1'b0},
        // R7 illegal digit
        '{128'h0000_0000_0000_0000_0000_0000_0000_0A5C, 32'h0000_0001, 32'h0, 1'b0,
          128'h0000_0000_0000_0000_0000_0000_0000_0A5C, 2'd3, 1'b1},
        // R7 illegal sign
        '{128'h0000_0000_0000_0000_0000_0000_0000_1239, 32'h0000_0001, 32'h0, 1'b0,
          128'h0000_0000_0000_0000_0000_0000_0000_1239, 2'd3, 1'b1},
        // R1 zero count unchanged; R8 negative
        '{128'h0000_0000_0000_0000_0000_0000_0000_042B, 32'h0000_0000, 32'h0, 1'b0,
          128'h0000_0000_0000_0000_0000_0000_0000_042B, 2'd1, 1'b0},
        // R8 zero digits with minus sign give zero code
        '{128'h0000_0000_0000_0000_0000_0000_0000_000B, 32'h0000_0005, 32'h0, 1'b0,
          128'h0000_0000_0000_0000_0000_0000_0000_000B, 2'd0, 1'b0},
        // R5 right 31 clears
        '{128'h0000_0000_0000_0000_0000_0001_2345_678C, 32'h0000_FFE1, 32'h0, 1'b0,
          128'h0000_0000_0000_0000_0000_0000_0000_000C, 2'd0, 1'b0}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin : main
        // R9 reset state
        repeat (2) @(posedge clk);
        #1;
        check("R9 reset acc", acc_out, '0);
        check("R9 reset cc", {126'd0, cc_out}, '0);
        check("R9 reset abort", {127'd0, abort}, '0);
        @(negedge clk) rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            acc_in   = VECS[i].acc;
            cnt_word = VECS[i].cw;
            idx_word = VECS[i].iw;
            idx_en   = VECS[i].ie;
            @(posedge clk);
            #1;
            check($sformatf("vec%0d acc", i), acc_out, VECS[i].exp);
            check($sformatf("vec%0d cc", i), {126'd0, cc_out}, {126'd0, VECS[i].cc});
            check($sformatf("vec%0d abort", i), {127'd0, abort}, {127'd0, VECS[i].ab});
        end

        // R9 one-cycle latency: outputs hold until the next rising edge
        @(negedge clk);
        acc_in   = 128'h0000_0000_0000_0000_0000_0001_2345_678C;
        cnt_word = 32'h0000_0001;
        idx_en   = 1'b0;
        #1;
        check("R9 hold before edge", acc_out, 128'h0000_0000_0000_0000_0000_0000_0000_000C);
        @(posedge clk);
        #1;
        check("R3 R9 left 1 after edge", acc_out, 128'h0000_0000_0000_0000_0000_0012_3456_780C);

        // R2 index field ignored when idx_en=0 even if huge
        @(negedge clk);
        idx_word = 32'h0003_FFFC;
        @(posedge clk);
        #1;
        check("R2 idx_en low ignores index", acc_out, 128'h0000_0000_0000_0000_0000_0012_3456_780C);

        // R9 reset mid-run clears outputs
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9 mid reset acc", acc_out, '0);
        check("R9 mid reset cc", {126'd0, cc_out}, '0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R3 after reset", acc_out, 128'h0000_0000_0000_0000_0000_0012_3456_780C);

        finish_run();
    end

endmodule